// File: doc/BRIEF.md
# ATM Cell Receive Port Responder (Multi-PHY Polled Bus)

This block is the physical-layer side of a shared, polled UTOPIA Level 2 style receive bus. It stores up to four complete 53-byte cells, which are loaded through a byte-write port. When the bus master polls the block's 5-bit address, the block answers on a shared "cell available" line. After that, the master can select the block and pull cell bytes out of it.

Selection is remembered from cycle to cycle. If the master releases the transfer enable in the middle of a cell, the block stops driving. When it is selected and enabled again, it carries on from the next unsent byte. If the enable stays low past the last byte of a cell and another cell is stored, that cell starts straight away.

The block does not drive any pad itself. Each shared line is given to the pad ring as a value plus an output enable, and a deasserted enable stands for high impedance. The transfer enable input is active low.

Top module: `utopia_rx_responder`

## Requirements
- R1: One clock after `bus_addr` equals `my_addr`, `cell_avail_oe` is 1 and `cell_avail` is 1 exactly when at least one complete cell is stored. In any other cycle, `cell_avail_oe` is 0.
- R2: A clock edge with `xfer_en_n` high and `bus_addr` equal to `my_addr` selects the block. A clock edge with `xfer_en_n` high and any other address deselects it. While `xfer_en_n` is low, the selection holds.
- R3: The block may be selected with no cell partly sent and a cell stored. In that case, the first edge that samples `xfer_en_n` low makes the block drive byte 0 of the cell with `rx_soc` 1. The following edges give bytes 1 to 52 in the order they were written, with `rx_soc` 0.
- R4: After an edge that samples `xfer_en_n` high, `rx_data_oe` and `rx_soc` are 0. An unselected block never drives. After reset, all output enables are 0.
- R5: A cell may be suspended part-way, either by `xfer_en_n` going high or by another device being selected. On the next enabled cycle after reselection, the cell resumes at the first unsent byte, with `rx_soc` 0.
- R6: If `xfer_en_n` stays low after byte 52, the next stored cell starts at once with `rx_soc` 1. If no cell is stored, the block keeps driving with `rx_soc` 0 and `rx_data` 0x00.
- R7: The queue holds 4 cells. A cell that has any byte written while 4 cells are stored is dropped whole.
- R8: A cell is written as bytes with `wr_valid` high, and the last byte also carries `wr_last`. Only a cell of exactly 53 bytes is stored. Shorter and longer cells are dropped.
- R9: When `my_addr` is 0x1F, the block never answers a poll and is never selected.
- R10: Cells are delivered in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| my_addr | input | 5 | This block's port address |
| bus_addr | input | 5 | Poll/select address from the bus master |
| xfer_en_n | input | 1 | Transfer enable from the master, active low |
| cell_avail | output | 1 | Poll answer: a complete cell is ready |
| cell_avail_oe | output | 1 | Drive enable for `cell_avail` |
| rx_data | output | 8 | Cell byte |
| rx_soc | output | 1 | Marks byte 0 of a cell |
| rx_data_oe | output | 1 | Drive enable for `rx_data` and `rx_soc` |
| wr_valid | input | 1 | Write byte strobe |
| wr_byte | input | 8 | Byte to load |
| wr_last | input | 1 | Marks the final byte of a cell being loaded |

## Verification
Directed sequences test each part of the transfer on its own:
- A plain select-and-read shows the start-of-cell timing.
- A deselect in the middle of a cell that goes to a different address tells a real resume apart from a restart.
- A read that runs past two cells tells a back-to-back start apart from the idle case with no cell left.
- Cells of 52 and 54 bytes, and a fifth cell written into a full queue, tell dropping apart from truncating.

A long random phase mixes polls to the block's own address, to other addresses and to 0x1F, toggles the enable, and runs writes of random length alongside reads. It is checked every cycle against a bench model of the queue.

// File: rtl/utopia_rx_responder.sv
module utopia_rx_responder #(
  parameter int DEPTH      = 4,
  parameter int CELL_BYTES = 53,
  parameter int AW         = 5,
  parameter int DW         = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] my_addr,
  input  logic [AW-1:0] bus_addr,
  input  logic          xfer_en_n,
  output logic          cell_avail,
  output logic          cell_avail_oe,
  output logic [DW-1:0] rx_data,
  output logic          rx_soc,
  output logic          rx_data_oe,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_byte,
  input  logic          wr_last
);
  localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int IDX_W  = $clog2(CELL_BYTES + 1);
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]    NULL_ADDR = {AW{1'b1}};
  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(CELL_BYTES - 1);
  localparam logic [IDX_W-1:0] FULL_LEN  = IDX_W'(CELL_BYTES);

  logic [DW-1:0]    mem [DEPTH][CELL_BYTES];
  logic [SLOT_W-1:0] rslot, wslot;
  logic [IDX_W-1:0]  ridx, widx;
  logic [CNT_W-1:0]  cnt;
  logic              sel, bad;

  function automatic logic [SLOT_W-1:0] nxt(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(DEPTH - 1)) ? '0 : s + 1'b1;
  endfunction

  wire addr_hit  = (bus_addr == my_addr) && (my_addr != NULL_ADDR);
  wire have_cell = (cnt != '0);
  wire sending   = (ridx != '0) || have_cell;
  wire at_last   = (ridx == LAST_IDX);
  wire pop       = !xfer_en_n && sel && sending && at_last;
  wire full      = (cnt == CNT_W'(DEPTH));
  wire bad_now   = bad || full || (widx >= FULL_LEN);
  wire push      = wr_valid && wr_last && !bad_now && (widx == LAST_IDX);

  always_ff @(posedge clk)
    if (wr_valid && !bad_now) mem[wslot][widx] <= wr_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_avail    <= 1'b0;
      cell_avail_oe <= 1'b0;
      rx_data       <= '0;
      rx_soc        <= 1'b0;
      rx_data_oe    <= 1'b0;
      sel           <= 1'b0;
      rslot         <= '0;
      ridx          <= '0;
      wslot         <= '0;
      widx          <= '0;
      bad           <= 1'b0;
      cnt           <= '0;
    end else begin
      cell_avail_oe <= addr_hit;
      cell_avail    <= addr_hit && have_cell;
      if (xfer_en_n) begin
        sel        <= addr_hit;
        rx_data_oe <= 1'b0;
        rx_soc     <= 1'b0;
      end else if (sel) begin
        rx_data_oe <= 1'b1;
        if (sending) begin
          rx_data <= mem[rslot][ridx];
          rx_soc  <= (ridx == '0);
          ridx    <= at_last ? '0 : ridx + 1'b1;
          if (at_last) rslot <= nxt(rslot);
        end else begin
          rx_data <= '0;
          rx_soc  <= 1'b0;
        end
      end else begin
        rx_data_oe <= 1'b0;
        rx_soc     <= 1'b0;
      end
      if (wr_valid) begin
        if (wr_last) begin
          widx <= '0;
          bad  <= 1'b0;
          if (push) wslot <= nxt(wslot);
        end else begin
          bad <= bad_now;
          if (widx < FULL_LEN) widx <= widx + 1'b1;
        end
      end
      cnt <= cnt + CNT_W'(push) - CNT_W'(pop);
    end
  end

  AST_POLL_OWN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    cell_avail_oe |-> $past(bus_addr) == $past(my_addr)); // R1
  AST_NULL_ADDR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    cell_avail_oe |-> $past(my_addr) != NULL_ADDR); // R9
  AST_FLOAT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_en_n |=> !rx_data_oe && !rx_soc); // R4
  AST_RESUME_NO_SOC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_data_oe) && $past(ridx) != '0 |-> !rx_soc); // R5
  AST_IDLE_NO_SOC: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_en_n && sel && !have_cell && ridx == '0 |=> !rx_soc); // R6
  AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)); // R7
endmodule

// File: tb/sim_utopia_rx_responder.sv
`timescale 1ns/1ps
module sim_utopia_rx_responder;
  localparam logic [4:0] OTHER = 5'd9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] maddr = 5'd6;
  logic [4:0] ba = 5'd0;
  logic en_n = 1'b1;
  logic wv = 1'b0, wl = 1'b0;
  logic [7:0] wb = 8'd0;
  logic cell_avail, cell_avail_oe, rx_soc, rx_data_oe;
  logic [7:0] rx_data;

  int checks = 0, errors = 0;

  logic [7:0] mcell [4][53];
  logic [7:0] mbuf [53];
  int mhead = 0, mtail = 0, mcnt = 0, mridx = 0, mwidx = 0;
  logic msel = 1'b0, mbad = 1'b0;

  always #2.5 clk = ~clk;

  utopia_rx_responder u0 (
    .clk(clk), .rst_n(rst_n), .my_addr(maddr), .bus_addr(ba), .xfer_en_n(en_n),
    .cell_avail(cell_avail), .cell_avail_oe(cell_avail_oe), .rx_data(rx_data),
    .rx_soc(rx_soc), .rx_data_oe(rx_data_oe), .wr_valid(wv), .wr_byte(wb), .wr_last(wl));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic addr_match(input logic [4:0] a, input logic [4:0] m);
    return (a == m) && (m != 5'h1F);
  endfunction

  task automatic step(input string tag);
    logic hit, e_aoe, e_av, e_doe, e_soc, pop, push, badnow, nsel;
    logic [7:0] e_dat;
    hit = addr_match(ba, maddr);
    e_aoe = hit; e_av = hit && (mcnt != 0);
    e_doe = 0; e_soc = 0; e_dat = 0; pop = 0; push = 0;
    nsel = en_n ? hit : msel;
    if (!en_n && msel) begin
      e_doe = 1;
      if (mridx != 0 || mcnt != 0) begin
        e_dat = mcell[mhead][mridx];
        e_soc = (mridx == 0);
        if (mridx == 52) begin mridx = 0; pop = 1; end else mridx++;
      end
    end
    if (wv) begin
      badnow = mbad || (mcnt == 4) || (mwidx >= 53);
      if (!badnow) mbuf[mwidx] = wb;
      if (wl) begin
        push = !badnow && (mwidx == 52);
        mwidx = 0; mbad = 0;
      end else begin
        mbad = badnow;
        if (mwidx < 53) mwidx++;
      end
    end
    if (push) begin mcell[mtail] = mbuf; mtail = (mtail + 1) % 4; end
    if (pop) mhead = (mhead + 1) % 4;
    mcnt = mcnt + int'(push) - int'(pop);
    msel = nsel;
    @(posedge clk); #1;
    chk({tag, " R1 avail_oe"}, 32'(cell_avail_oe), 32'(e_aoe));
    if (e_aoe) chk({tag, " R1 avail"}, 32'(cell_avail), 32'(e_av));
    chk({tag, " R4 data_oe"}, 32'(rx_data_oe), 32'(e_doe));
    chk({tag, " R3 soc"}, 32'(rx_soc), 32'(e_soc));
    if (e_doe) chk({tag, " R3 data"}, 32'(rx_data), 32'(e_dat));
  endtask

  task automatic write_cell(input int len, input string tag);
    for (int i = 0; i < len; i++) begin
      wv = 1; wb = 8'($urandom); wl = (i == len - 1);
      step(tag);
    end
    wv = 0; wl = 0;
  endtask

  task automatic run(input logic e, input logic [4:0] a, input int n, input string tag);
    en_n = e; ba = a;
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++; checks++;
    $display("FAIL watchdog R0 actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int wact, wcnt, wtgt, r;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    chk("R4 reset data_oe", 32'(rx_data_oe), 0);
    chk("R4 reset avail_oe", 32'(cell_avail_oe), 0);
    chk("R4 reset soc", 32'(rx_soc), 0);
    rst_n = 1;

    run(1, maddr, 1, "R1 empty poll");
    write_cell(53, "R8 good A");
    write_cell(52, "R8 short");
    write_cell(54, "R8 long");
    write_cell(53, "R8 good B");
    chk("R8 two cells kept", 32'(mcnt), 2);
    run(1, maddr, 1, "R2 select");
    run(0, maddr, 20, "R3 first part");
    run(1, OTHER, 1, "R5 deselect");
    run(0, OTHER, 4, "R2 other selected");
    run(1, maddr, 1, "R5 reselect");
    run(0, maddr, 33 + 53 + 4, "R5 R6 resume and chain");
    run(1, OTHER, 1, "R4 release");

    for (int k = 0; k < 5; k++) write_cell(53, "R7 fill");
    chk("R7 queue capped", 32'(mcnt), 4);
    run(1, maddr, 1, "R7 poll full");
    run(0, maddr, 4 * 53 + 3, "R10 drain in order");
    run(1, OTHER, 1, "R4 release");

    maddr = 5'h1F;
    write_cell(53, "R9 load");
    run(1, 5'h1F, 2, "R9 poll null");
    run(0, 5'h1F, 5, "R9 no drive");
    chk("R9 never drives", 32'(rx_data_oe), 0);
    run(1, OTHER, 1, "R9 leave");
    maddr = 5'd6;

    wact = 0; wcnt = 0; wtgt = 53;
    for (int c = 0; c < 6000; c++) begin
      if ($urandom % 12 == 0) en_n = ~en_n;
      r = $urandom % 4;
      if (en_n || $urandom % 20 == 0)
        ba = (r == 0) ? maddr : (r == 1) ? OTHER : (r == 2) ? 5'h1F : 5'($urandom);
      if (wact == 0 && $urandom % 6 == 0) begin
        wact = 1; wcnt = 0;
        wtgt = ($urandom % 5 == 0) ? 51 + int'($urandom % 4) : 53;
      end
      if (wact != 0 && $urandom % 2 == 0) begin
        wv = 1; wb = 8'($urandom); wl = (wcnt == wtgt - 1); wcnt++;
        if (wl) wact = 0;
      end else begin
        wv = 0; wl = 0;
      end
      step("random R2 R5 R6 R7 R8 R10");
    end
    wv = 0; wl = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule